// File: doc/BRIEF.md
# Picture-in-Picture Window Controller

This block places a reduced secondary picture on top of the main video raster. It counts clocks from the rising edge of the main horizontal sync and counts lines from the rising edge of the active-high vertical sync. From these counts it derives a window of one of two fixed sizes, anchored in one of four corners of the active area. While the raster is inside that window, it issues read addresses to an external synchronous sub-picture field memory. The memory returns data one clock later. The block then drives a registered select strobe, aligned with that returned data, which switches the downstream mixer from main video to the sub-picture.

A two-pixel, two-line ring just outside the window can be drawn as a solid frame with a programmable luma level. Display needs both a control bit and an external enable pin. A freeze control is sampled once per field and then blocks write requests to the field memory, so the stored picture stops changing. Each stored sample is 6 bits wide. Each memory line holds 171 luma samples. Chroma is stored as 57 combined slots per line, one slot for every three luma pixels, with B-Y and R-Y alternating, so each colour-difference component gets one sample per six luma pixels.

Top module: `pip_window_ctrl`

## Requirements
- R1: The pixel counter clears on the clock edge where `hsync_i` is first seen high and then advances by one per clock. The line counter clears on a rising edge of `vsync_i` and advances by one on each rising edge of `hsync_i`. As a result, the first read of a window line happens exactly at pixel count x0.
- R2: `size_i`=0 selects the one-ninth window, 171 pixels by 69 lines. `size_i`=1 selects the one-sixteenth window, 128 pixels by 52 lines. `rd_en_o` is high for exactly that many pixels on each window line.
- R3: `corner_i` bit 0 set places the window on the right and bit 1 set places it at the bottom. The left edge is H_ACT_START+H_MARGIN. The right edge (exclusive) is H_ACT_START+H_ACT_W-H_MARGIN. The top edge is V_ACT_START+V_MARGIN. The bottom edge (exclusive) is V_ACT_START+V_ACT_H-V_MARGIN. Outside the window and ring, the select and pixel outputs are zero.
- R4: Inside the window, `rd_en_o` is high and `rd_y_addr_o` equals line*171 + pixel, where line and pixel are measured from the window's top-left corner. `rd_en_o` is low everywhere else.
- R5: `rd_c_addr_o` equals line*57 + pixel/3. One clock later, `pip_c_red_o` is 1 when that slot index is odd (R-Y) and 0 when it is even (B-Y). `pip_c_red_o` is 0 outside the window.
- R6: For a window pixel, one clock after its address is issued, `pip_sel_o`=1 and `pip_y_o`/`pip_c_o` carry `mem_y_i`/`mem_c_i`.
- R7: With `frame_on_i`=1, the ring of width 2 around the window gives `pip_sel_o`=1, `pip_y_o`=`frame_lvl_i` and `pip_c_o`=0. With `frame_on_i`=0, the ring outputs are all zero.
- R8: Nothing is displayed or read unless both `pip_on_i` and `disp_en_i` are 1. When either is 0, `pip_sel_o` and `rd_en_o` stay low.
- R9: `freeze_i` is sampled only on a rising edge of `vsync_i`. `mem_we_o` equals `wr_req_i` while the sampled value is 0 and is held at 0 while it is 1.
- R10: During and right after reset, `rd_en_o`, `pip_sel_o`, `pip_y_o`, `pip_c_o`, `pip_c_red_o` and `mem_we_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hsync_i | input | 1 | Main horizontal sync, rising edge used |
| vsync_i | input | 1 | Main vertical sync, active high |
| pip_on_i | input | 1 | Sub-picture display control bit |
| disp_en_i | input | 1 | External display enable, active high |
| size_i | input | 1 | 0 = one-ninth, 1 = one-sixteenth |
| corner_i | input | 2 | bit0 right, bit1 bottom |
| frame_on_i | input | 1 | Frame ring enable |
| frame_lvl_i | input | 6 | Frame luma level |
| freeze_i | input | 1 | Freeze request, taken per field |
| wr_req_i | input | 1 | Write request from the sub-picture path |
| mem_y_i | input | 6 | Luma read data, one clock after address |
| mem_c_i | input | 6 | Chroma read data, one clock after address |
| rd_en_o | output | 1 | Field memory read enable |
| rd_y_addr_o | output | AW | Luma read address |
| rd_c_addr_o | output | CAW | Combined chroma slot read address |
| mem_we_o | output | 1 | Gated field memory write enable |
| pip_sel_o | output | 1 | Select strobe, sub-picture over main |
| pip_y_o | output | 6 | Sub-picture luma out |
| pip_c_o | output | 6 | Sub-picture colour difference out |
| pip_c_red_o | output | 1 | Current chroma sample is R-Y |

## Verification
The bench shrinks the raster to a 255-count horizontal and 160-count vertical counter range with a 240 by 140 active area. The window sizes stay at their real values of 171 by 69 and 128 by 52. With these values, every corner and both sizes fit in a 250-clock captured line. Short filler lines carry the line counter to the top ring, the first and last window lines and the bottom ring within a few hundred clocks. Each captured pixel is therefore compared against a model of position, address, chroma phase and frame level in all eight placements.

// File: rtl/pip_pkg.sv
package pip_pkg;
  localparam int PIX_W      = 6;
  localparam int FRAME_W    = 2;  // ring width in pixels and lines
  localparam int C_PER_SLOT = 3;  // luma pixels per combined chroma slot

  typedef enum logic {
    SZ_NINTH     = 1'b0,
    SZ_SIXTEENTH = 1'b1
  } win_size_e;

  typedef struct packed {
    logic bottom;
    logic right;
  } corner_t;
endpackage

// File: rtl/pip_raster_cnt.sv
module pip_raster_cnt #(
  parameter int HW      = 11,
  parameter int VW      = 10,
  parameter int H_TOTAL = 910,
  parameter int V_TOTAL = 263
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hsync_i,
  input  logic          vsync_i,
  output logic [HW-1:0] hcnt_o,
  output logic [VW-1:0] vcnt_o,
  output logic          vs_rise_o
);
  localparam logic [HW-1:0] H_LAST = HW'(H_TOTAL - 1);
  localparam logic [VW-1:0] V_LAST = VW'(V_TOTAL - 1);

  logic hs_d, vs_d, hs_rise;

  assign hs_rise   = hsync_i & ~hs_d;
  assign vs_rise_o = vsync_i & ~vs_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hs_d   <= 1'b0;
      vs_d   <= 1'b0;
      hcnt_o <= '0;
      vcnt_o <= '0;
    end else begin
      hs_d <= hsync_i;
      vs_d <= vsync_i;
      if (hs_rise)               hcnt_o <= '0;
      else if (hcnt_o != H_LAST) hcnt_o <= hcnt_o + 1'b1;
      if (vs_rise_o)                     vcnt_o <= '0;
      else if (hs_rise && vcnt_o != V_LAST) vcnt_o <= vcnt_o + 1'b1;
    end
  end

  AST_HCNT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hsync_i) |=> hcnt_o == '0); // R1
  AST_HCNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$rose(hsync_i) && hcnt_o != H_LAST) |=> hcnt_o == $past(hcnt_o) + 1'b1); // R1
  AST_VCNT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vsync_i) |=> vcnt_o == '0); // R1
endmodule

// File: rtl/pip_geom.sv
module pip_geom import pip_pkg::*; #(
  parameter int HW          = 11,
  parameter int VW          = 10,
  parameter int H_ACT_START = 140,
  parameter int H_ACT_W     = 752,
  parameter int H_MARGIN    = 16,
  parameter int V_ACT_START = 20,
  parameter int V_ACT_H     = 240,
  parameter int V_MARGIN    = 12,
  parameter int NINTH_W     = 171,
  parameter int NINTH_H     = 69,
  parameter int SIXT_W      = 128,
  parameter int SIXT_H      = 52
) (
  input  logic [HW-1:0] hcnt_i,
  input  logic [VW-1:0] vcnt_i,
  input  win_size_e     size_i,
  input  corner_t       corner_i,
  output logic          in_win_o,
  output logic          in_ring_o,
  output logic [HW-1:0] px_o,
  output logic [VW-1:0] ln_o
);
  localparam logic [HW-1:0] X_LEFT    = HW'(H_ACT_START + H_MARGIN);
  localparam logic [HW-1:0] X_R_END   = HW'(H_ACT_START + H_ACT_W - H_MARGIN);
  localparam logic [VW-1:0] Y_TOP     = VW'(V_ACT_START + V_MARGIN);
  localparam logic [VW-1:0] Y_B_END   = VW'(V_ACT_START + V_ACT_H - V_MARGIN);
  localparam logic [HW-1:0] FW_H      = HW'(FRAME_W);
  localparam logic [VW-1:0] FW_V      = VW'(FRAME_W);

  logic [HW-1:0] w, x0, x1;
  logic [VW-1:0] h, y0, y1;
  logic          h_in, v_in, h_ring, v_ring;

  always_comb begin
    w  = (size_i == SZ_SIXTEENTH) ? HW'(SIXT_W) : HW'(NINTH_W);
    h  = (size_i == SZ_SIXTEENTH) ? VW'(SIXT_H) : VW'(NINTH_H);
    x0 = corner_i.right  ? X_R_END - w : X_LEFT;
    y0 = corner_i.bottom ? Y_B_END - h : Y_TOP;
    x1 = x0 + w;
    y1 = y0 + h;
    h_in   = (hcnt_i >= x0) && (hcnt_i < x1);
    v_in   = (vcnt_i >= y0) && (vcnt_i < y1);
    h_ring = (hcnt_i >= x0 - FW_H) && (hcnt_i < x1 + FW_H);
    v_ring = (vcnt_i >= y0 - FW_V) && (vcnt_i < y1 + FW_V);
    in_win_o  = h_in && v_in;
    in_ring_o = h_ring && v_ring && !in_win_o;
    px_o = hcnt_i - x0;
    ln_o = vcnt_i - y0;
  end
endmodule

// File: rtl/pip_addr_gen.sv
module pip_addr_gen import pip_pkg::*; #(
  parameter int HW          = 11,
  parameter int VW          = 10,
  parameter int AW          = 14,
  parameter int CAW         = 12,
  parameter int LINE_STRIDE = 171,
  parameter int C_STRIDE    = 57
) (
  input  logic [HW-1:0]  px_i,
  input  logic [VW-1:0]  ln_i,
  output logic [AW-1:0]  y_addr_o,
  output logic [CAW-1:0] c_addr_o,
  output logic           c_odd_o
);
  logic [HW-1:0] slot;

  assign slot     = px_i / HW'(C_PER_SLOT);
  assign y_addr_o = AW'(ln_i) * AW'(LINE_STRIDE) + AW'(px_i);
  assign c_addr_o = CAW'(ln_i) * CAW'(C_STRIDE) + CAW'(slot);
  assign c_odd_o  = slot[0];  // odd slot carries R-Y
endmodule

// File: rtl/pip_window_ctrl.sv
module pip_window_ctrl import pip_pkg::*; #(
  parameter int H_TOTAL     = 910,
  parameter int V_TOTAL     = 263,
  parameter int H_ACT_START = 140,
  parameter int H_ACT_W     = 752,
  parameter int H_MARGIN    = 16,
  parameter int V_ACT_START = 20,
  parameter int V_ACT_H     = 240,
  parameter int V_MARGIN    = 12,
  parameter int NINTH_W     = 171,
  parameter int NINTH_H     = 69,
  parameter int SIXT_W      = 128,
  parameter int SIXT_H      = 52,
  localparam int HW      = $clog2(H_TOTAL) + 1,
  localparam int VW      = $clog2(V_TOTAL) + 1,
  localparam int C_SLOTS = (NINTH_W + C_PER_SLOT - 1) / C_PER_SLOT,
  localparam int AW      = $clog2(NINTH_W * NINTH_H),
  localparam int CAW     = $clog2(C_SLOTS * NINTH_H)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hsync_i,
  input  logic             vsync_i,
  input  logic             pip_on_i,
  input  logic             disp_en_i,
  input  logic             size_i,
  input  logic [1:0]       corner_i,
  input  logic             frame_on_i,
  input  logic [PIX_W-1:0] frame_lvl_i,
  input  logic             freeze_i,
  input  logic             wr_req_i,
  input  logic [PIX_W-1:0] mem_y_i,
  input  logic [PIX_W-1:0] mem_c_i,
  output logic             rd_en_o,
  output logic [AW-1:0]    rd_y_addr_o,
  output logic [CAW-1:0]   rd_c_addr_o,
  output logic             mem_we_o,
  output logic             pip_sel_o,
  output logic [PIX_W-1:0] pip_y_o,
  output logic [PIX_W-1:0] pip_c_o,
  output logic             pip_c_red_o
);
  logic [HW-1:0] hcnt, px;
  logic [VW-1:0] vcnt, ln;
  logic          vs_rise, in_win, in_ring, c_odd, disp_en;
  logic          win_q, border_q, red_q, freeze_q;

  pip_raster_cnt #(
    .HW(HW), .VW(VW), .H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL)
  ) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .hsync_i(hsync_i), .vsync_i(vsync_i),
    .hcnt_o(hcnt), .vcnt_o(vcnt), .vs_rise_o(vs_rise)
  );

  pip_geom #(
    .HW(HW), .VW(VW),
    .H_ACT_START(H_ACT_START), .H_ACT_W(H_ACT_W), .H_MARGIN(H_MARGIN),
    .V_ACT_START(V_ACT_START), .V_ACT_H(V_ACT_H), .V_MARGIN(V_MARGIN),
    .NINTH_W(NINTH_W), .NINTH_H(NINTH_H), .SIXT_W(SIXT_W), .SIXT_H(SIXT_H)
  ) u_geom (
    .hcnt_i(hcnt), .vcnt_i(vcnt),
    .size_i(win_size_e'(size_i)), .corner_i(corner_t'(corner_i)),
    .in_win_o(in_win), .in_ring_o(in_ring), .px_o(px), .ln_o(ln)
  );

  pip_addr_gen #(
    .HW(HW), .VW(VW), .AW(AW), .CAW(CAW),
    .LINE_STRIDE(NINTH_W), .C_STRIDE(C_SLOTS)
  ) u_addr (
    .px_i(px), .ln_i(ln),
    .y_addr_o(rd_y_addr_o), .c_addr_o(rd_c_addr_o), .c_odd_o(c_odd)
  );

  assign disp_en = pip_on_i & disp_en_i;
  assign rd_en_o = disp_en & in_win;

  // one-stage pipe matches the read latency of the field memory
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q    <= 1'b0;
      border_q <= 1'b0;
      red_q    <= 1'b0;
      freeze_q <= 1'b0;
    end else begin
      win_q    <= disp_en & in_win;
      border_q <= disp_en & frame_on_i & in_ring;
      red_q    <= disp_en & in_win & c_odd;
      if (vs_rise) freeze_q <= freeze_i;
    end
  end

  assign pip_sel_o   = win_q | border_q;
  assign pip_y_o     = border_q ? frame_lvl_i : (win_q ? mem_y_i : '0);
  assign pip_c_o     = win_q ? mem_c_i : '0;
  assign pip_c_red_o = red_q;
  assign mem_we_o    = wr_req_i & ~freeze_q;

  AST_SEL_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pip_sel_o |-> $past(pip_on_i && disp_en_i)); // R8
  AST_Y_ADDR_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_o |-> rd_y_addr_o < AW'(NINTH_W * NINTH_H)); // R4
  AST_C_ADDR_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_o |-> rd_c_addr_o < CAW'(C_SLOTS * NINTH_H)); // R5
  AST_FREEZE_PER_FIELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$rose(vsync_i) |=> $stable(freeze_q)); // R9
  AST_RING_NO_CHROMA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pip_sel_o && pip_y_o == frame_lvl_i && $past(frame_on_i && in_ring)) |-> pip_c_o == '0); // R7
endmodule

// File: tb/pip_window_ctrl_bench.sv
module pip_window_ctrl_bench;
  localparam int CLK_PERIOD  = 10;
  localparam int H_TOTAL     = 255;
  localparam int V_TOTAL     = 160;
  localparam int H_ACT_START = 20;
  localparam int H_ACT_W     = 240;
  localparam int H_MARGIN    = 16;
  localparam int V_ACT_START = 4;
  localparam int V_ACT_H     = 140;
  localparam int V_MARGIN    = 12;
  localparam int N9W = 171, N9H = 69, S16W = 128, S16H = 52;
  localparam int CSL = 57;
  localparam int AW  = $clog2(N9W * N9H);
  localparam int CAW = $clog2(CSL * N9H);
  localparam int CAP = 250;

  logic clk = 1'b0, rst_n = 1'b0;
  logic hsync = 0, vsync = 0, pip_on = 0, disp_en = 0, size = 0, frame_on = 0;
  logic freeze = 0, wr_req = 0;
  logic [1:0] corner = 0;
  logic [5:0] frame_lvl = 0, mem_y = 0, mem_c = 0;
  logic rd_en, mem_we, sel, c_red;
  logic [AW-1:0] rd_y_addr;
  logic [CAW-1:0] rd_c_addr;
  logic [5:0] pip_y, pip_c;
  int n_checks = 0, n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pip_window_ctrl #(
    .H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL), .H_ACT_START(H_ACT_START), .H_ACT_W(H_ACT_W),
    .H_MARGIN(H_MARGIN), .V_ACT_START(V_ACT_START), .V_ACT_H(V_ACT_H), .V_MARGIN(V_MARGIN),
    .NINTH_W(N9W), .NINTH_H(N9H), .SIXT_W(S16W), .SIXT_H(S16H)
  ) u_pip_window_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .hsync_i(hsync), .vsync_i(vsync),
    .pip_on_i(pip_on), .disp_en_i(disp_en), .size_i(size), .corner_i(corner),
    .frame_on_i(frame_on), .frame_lvl_i(frame_lvl), .freeze_i(freeze), .wr_req_i(wr_req),
    .mem_y_i(mem_y), .mem_c_i(mem_c), .rd_en_o(rd_en), .rd_y_addr_o(rd_y_addr),
    .rd_c_addr_o(rd_c_addr), .mem_we_o(mem_we), .pip_sel_o(sel), .pip_y_o(pip_y),
    .pip_c_o(pip_c), .pip_c_red_o(c_red)
  );

  function automatic logic [5:0] yfn(input int a);
    return 6'(a ^ (a >> 6));
  endfunction
  function automatic logic [5:0] cfn(input int a);
    return 6'(a + (a >> 6) + 13);
  endfunction

  // synchronous field memory model, one clock read latency
  always_ff @(posedge clk) begin
    mem_y <= yfn(int'(rd_y_addr));
    mem_c <= cfn(int'(rd_c_addr));
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", n_err, n_checks);
  endtask

  function automatic int win_x0(input int sz, input int cor);
    int w = sz ? S16W : N9W;
    return (cor & 1) ? (H_ACT_START + H_ACT_W - H_MARGIN - w) : (H_ACT_START + H_MARGIN);
  endfunction
  function automatic int win_y0(input int sz, input int cor);
    int h = sz ? S16H : N9H;
    return (cor & 2) ? (V_ACT_START + V_ACT_H - V_MARGIN - h) : (V_ACT_START + V_MARGIN);
  endfunction

  task automatic geo(input int sz, input int cor, input int l, input int x,
                     output bit win, output bit ring, output int px, output int ln);
    int w = sz ? S16W : N9W;
    int h = sz ? S16H : N9H;
    int x0 = win_x0(sz, cor);
    int y0 = win_y0(sz, cor);
    win  = (x >= x0) && (x < x0 + w) && (l >= y0) && (l < y0 + h);
    ring = !win && (x >= x0 - 2) && (x < x0 + w + 2) && (l >= y0 - 2) && (l < y0 + h + 2);
    px = x - x0;
    ln = l - y0;
  endtask

  task automatic goto_line(input int l);
    @(negedge clk) vsync = 1;
    @(negedge clk) vsync = 0;
    for (int i = 1; i < l; i++) begin
      @(negedge clk) hsync = 1;
      @(negedge clk) hsync = 0;
      @(negedge clk);
    end
  endtask

  // vsync, reach line l, capture one full line and compare each pixel with the model
  task automatic run_line(input int sz, input int cor, input bit frm, input logic [5:0] lvl,
                          input bit on, input bit den, input int l,
                          output int n_rd, output int n_sel);
    bit bad[6];
    int ba[6], be[6];
    string tags[6] = '{"R4", "R4", "R5", "R6", "R7", "R3"};
    string what[6] = '{"rd_en", "luma addr", "chroma addr/phase", "window pixel", "ring pixel", "outside pixel"};
    int first_rd = -1, exp_rd, w;
    bit win, ring, en;
    int px, ln;
    size = sz[0]; corner = 2'(cor); frame_on = frm; frame_lvl = lvl; pip_on = on; disp_en = den;
    en = on && den;
    n_rd = 0; n_sel = 0;
    for (int k = 0; k < 6; k++) begin bad[k] = 0; ba[k] = 0; be[k] = 0; end
    goto_line(l);
    @(negedge clk) hsync = 1;
    for (int j = 0; j < CAP; j++) begin
      @(negedge clk);
      hsync = 0;
      geo(sz, cor, l, j, win, ring, px, ln);
      if (rd_en) begin n_rd++; if (first_rd < 0) first_rd = j; end
      if (rd_en !== (en && win) && !bad[0]) begin bad[0] = 1; ba[0] = int'(rd_en); be[0] = int'(en && win); end
      if (en && win && rd_en) begin
        if (int'(rd_y_addr) != ln * N9W + px && !bad[1]) begin
          bad[1] = 1; ba[1] = int'(rd_y_addr); be[1] = ln * N9W + px;
        end
        if (int'(rd_c_addr) != ln * CSL + px / 3 && !bad[2]) begin
          bad[2] = 1; ba[2] = int'(rd_c_addr); be[2] = ln * CSL + px / 3;
        end
      end
      if (j >= 1) begin
        int act, exp, k;
        bit e_red;
        geo(sz, cor, l, j - 1, win, ring, px, ln);
        if (sel) n_sel++;
        e_red = en && win && (((px / 3) & 1) == 1);
        if (c_red !== e_red && !bad[2]) begin bad[2] = 1; ba[2] = int'(c_red); be[2] = int'(e_red); end
        act = (int'(sel) << 12) | (int'(pip_y) << 6) | int'(pip_c);
        if (en && win)
          exp = (1 << 12) | (int'(yfn(ln * N9W + px)) << 6) | int'(cfn(ln * CSL + px / 3));
        else if (en && frm && ring)
          exp = (1 << 12) | (int'(lvl) << 6);
        else
          exp = 0;
        k = win ? 3 : (ring ? 4 : 5);
        if (act != exp && !bad[k]) begin bad[k] = 1; ba[k] = act; be[k] = exp; end
      end
    end
    for (int k = 0; k < 6; k++) chk(!bad[k], tags[k], what[k], ba[k], be[k]);
    w = sz ? S16W : N9W;
    geo(sz, cor, l, win_x0(sz, cor), win, ring, px, ln);
    exp_rd = (en && win) ? w : 0;
    chk(n_rd == exp_rd, "R2", "reads per line", n_rd, exp_rd);
    if (exp_rd > 0) chk(first_rd == win_x0(sz, cor), "R1", "first read pixel", first_rd, win_x0(sz, cor));
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!rd_en && !sel && pip_y == 0 && pip_c == 0 && !c_red && !mem_we, "R10", "outputs in reset",
        int'({rd_en, sel, c_red, mem_we}), 0);
    rst_n = 1;
    @(negedge clk);
    chk(!rd_en && !sel && pip_y == 0 && pip_c == 0 && !c_red && !mem_we, "R10", "outputs after reset",
        int'({rd_en, sel, c_red, mem_we}), 0);
  endtask

  // R2 R3 R6 R7: every size/corner, lines around both vertical edges of the window
  task automatic t_geometry();
    int nr, ns;
    for (int sz = 0; sz < 2; sz++)
      for (int cor = 0; cor < 4; cor++) begin
        int y0 = win_y0(sz, cor);
        int h = sz ? S16H : N9H;
        logic [5:0] lvl = 6'(7 + cor * 11 + sz * 5);
        run_line(sz, cor, 1, lvl, 1, 1, y0 - 2, nr, ns);
        run_line(sz, cor, 1, lvl, 1, 1, y0, nr, ns);
        run_line(sz, cor, 1, lvl, 1, 1, y0 + h - 1, nr, ns);
        run_line(sz, cor, 1, lvl, 1, 1, y0 + h + 1, nr, ns);
        run_line(sz, cor, 1, lvl, 1, 1, y0 + h + 2, nr, ns);
      end
  endtask

  // R7: frame disabled leaves the ring dark
  task automatic t_frame_off();
    int nr, ns;
    run_line(0, 1, 0, 6'h3f, 1, 1, win_y0(0, 1) - 1, nr, ns);
    chk(ns == 0, "R7", "sel pixels on ring line with frame off", ns, 0);
    run_line(1, 2, 0, 6'h3f, 1, 1, win_y0(1, 2), nr, ns);
    chk(ns == S16W, "R7", "sel pixels on window line with frame off", ns, S16W);
  endtask

  // R8: both enables are needed
  task automatic t_enable();
    int nr, ns;
    run_line(0, 0, 1, 6'h2a, 0, 1, win_y0(0, 0), nr, ns);
    chk(nr == 0 && ns == 0, "R8", "control bit off", nr + ns, 0);
    run_line(0, 3, 1, 6'h2a, 1, 0, win_y0(0, 3) - 1, nr, ns);
    chk(nr == 0 && ns == 0, "R8", "enable pin low", nr + ns, 0);
    run_line(0, 3, 1, 6'h2a, 1, 1, win_y0(0, 3), nr, ns);
    chk(ns == N9W + 4, "R8", "both enables high", ns, N9W + 4);
  endtask

  // R9: freeze takes effect only at a vertical sync rising edge
  task automatic t_freeze();
    freeze = 0; wr_req = 1;
    @(negedge clk) vsync = 1;
    @(negedge clk) vsync = 0;
    chk(mem_we === 1'b1, "R9", "write passes unfrozen", int'(mem_we), 1);
    freeze = 1;
    repeat (3) @(negedge clk);
    chk(mem_we === 1'b1, "R9", "freeze before field edge", int'(mem_we), 1);
    vsync = 1;
    @(negedge clk) vsync = 0;
    chk(mem_we === 1'b0, "R9", "write blocked after field edge", int'(mem_we), 0);
    freeze = 0;
    repeat (3) @(negedge clk);
    chk(mem_we === 1'b0, "R9", "unfreeze waits for field edge", int'(mem_we), 0);
    vsync = 1;
    @(negedge clk) vsync = 0;
    chk(mem_we === 1'b1, "R9", "write restored", int'(mem_we), 1);
    wr_req = 0;
    @(negedge clk);
    chk(mem_we === 1'b0, "R9", "no request no write", int'(mem_we), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    n_checks++; n_err++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_geometry();
    t_frame_off();
    t_enable();
    t_freeze();
    summary();
    $finish;
  end
endmodule